// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block takes one shared-scratchpad access from a group of 32 lanes and turns it into a short series of passes over a banked, word-wide memory. Each lane carries an active flag and a word address. In every clock of a pass the block names the lanes that are served, and for each bank it gives an enable and the single word address that bank must access. No bank ever sees two different addresses in one pass. Lanes that ask for the same word share one access, so a read to the same word by many lanes costs nothing extra.

A mode input, sampled when the access is accepted, selects between two layouts. In the wide layout there are 32 banks and all 32 lanes compete as one group, so any lane can conflict with any other. In the narrow layout there are 16 banks and the access is split into two groups: the lower 16 lanes are finished first, then the upper 16, and the two groups never share a pass. The input side uses a valid/ready handshake and takes a new access only when the previous one has finished. The pass that completes the access is flagged as the last one.

Top module: `smem_bank_arbiter`

## Requirements
- R1: After reset `req_ready` is 1 and `pass_valid` is 0. An access is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its first pass is shown in the very next cycle. `req_ready` stays 0 while passes are being shown and returns to 1 in the cycle after the last pass.
- R2: `req_wide` is sampled at accept. When it is 1 there are 32 banks and the bank of a lane is address bits [4:0]. When it is 0 there are 16 banks and the bank is address bits [3:0], and bank outputs 16 to 31 stay disabled.
- R3: In each pass, `pass_bank_en` bit b is 1 exactly when bank b is accessed. Field b of `pass_bank_addr` (bits b*AW and up, AW = 12) then holds the address served by that bank.
- R4: Inside a bank, a pass serves the address of the lowest-numbered lane still waiting in the current group. Waiting lanes that hold a different address in that bank stay for later passes.
- R5: Every waiting lane in the current group whose address equals a served address is granted in that same pass. Identical addresses never add a pass.
- R6: In narrow mode no pass grants lanes from both halves. No lane of 16 to 31 is granted while any active lane of 0 to 15 is still waiting. A half with no active lanes takes no pass.
- R7: In wide mode the access is not split, so lanes of different halves that map to the same bank with different addresses need separate passes. Lanes in different banks share one pass.
- R8: Inactive lanes are never granted and never cause a pass. An access with no active lanes produces exactly one pass with an all-zero grant, and that pass is flagged last.
- R9: Every active lane is granted exactly once. `pass_last` is 1 on the final pass only. The number of passes is the largest count of distinct addresses in any one bank, summed over both halves in narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is offered |
| req_ready | output | 1 | The block is idle and can take an access |
| req_wide | input | 1 | 1: 32 banks, one group; 0: 16 banks, two halves |
| req_active | input | 32 | Per-lane active flags |
| req_addr | input | 384 | Per-lane word addresses, lane i at bits i*12 and up |
| pass_valid | output | 1 | A pass is shown this cycle |
| pass_grant | output | 32 | Lanes served by this pass |
| pass_bank_en | output | 32 | Banks accessed by this pass |
| pass_bank_addr | output | 384 | Per-bank addresses, bank b at bits b*12 and up |
| pass_last | output | 1 | This pass completes the access |

## Verification
In one pass the block both resolves a bank conflict, where the lowest lane wins and the others wait, and merges lanes that hold the same address. These two actions meet when one bank holds a repeated address together with a different one. The directed test places lanes 3 and 9 on one word and lane 5 on another word of the same bank. It then expects lanes 3 and 9 in the first pass and lane 5 alone in the second, with the bank field showing each served address in turn. The same overlap shows up between half sequencing and bank conflict in narrow mode. There, two lanes that do not collide in wide mode are still expected in separate, ordered passes.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  localparam int unsigned ARB_LANES_DEF = 32;
  localparam int unsigned ARB_AW_DEF    = 12;
  localparam int unsigned ARB_BANKS_DEF = 32;

endpackage

// File: rtl/smem_lane_cmp.sv
// Per-lane bank index for the latched mode, and the lane-by-lane
// address equality matrix used to merge identical addresses.
module smem_lane_cmp #(
  parameter int unsigned LANES = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned NB    = 32,
  localparam int unsigned BW   = $clog2(NB)
) (
  input  logic                  wide,
  input  logic [LANES*AW-1:0]   addr_flat,
  output logic [LANES*BW-1:0]   bank_flat,
  output logic [LANES*LANES-1:0] same_addr
);

  logic [AW-1:0] lane_addr [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_addr[i] = addr_flat[i*AW +: AW];

    // Narrow layout drops the top bank bit: half the banks
    assign bank_flat[i*BW +: BW] = wide ? lane_addr[i][BW-1:0]
                                        : {1'b0, lane_addr[i][BW-2:0]};

    for (genvar j = 0; j < LANES; j++) begin : g_pair
      assign same_addr[i*LANES + j] = (lane_addr[i] == lane_addr[j]);
    end
  end

endmodule

// File: rtl/smem_pass_pick.sv
// Picks, for each bank, the lowest waiting lane (the leader), and grants
// every waiting lane whose address matches some leader's address.
module smem_pass_pick #(
  parameter int unsigned LANES = 32,
  parameter int unsigned BW    = 5
) (
  input  logic [LANES-1:0]       pend,
  input  logic [LANES*BW-1:0]    bank_flat,
  input  logic [LANES*LANES-1:0] same_addr,
  output logic [LANES-1:0]       leader,
  output logic [LANES-1:0]       grant
);

  logic [BW-1:0] lane_bank [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    assign lane_bank[i] = bank_flat[i*BW +: BW];
  end

  // A lane leads its bank when no lower waiting lane uses that bank
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      leader[j] = pend[j];
      for (int i = 0; i < LANES; i++) begin
        if (i < j && pend[i] && (lane_bank[i] == lane_bank[j])) begin
          leader[j] = 1'b0;
        end
      end
    end
  end

  // Equal addresses share a bank, so a match with any leader is a
  // match with the leader of this lane's own bank
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      grant[j] = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        if (i <= j && leader[i] && same_addr[i*LANES + j]) begin
          grant[j] = pend[j];
        end
      end
    end
  end

endmodule

// File: rtl/smem_bank_route.sv
// Steers each leader's address onto its bank's output field.
module smem_bank_route #(
  parameter int unsigned LANES = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned NB    = 32,
  localparam int unsigned BW   = $clog2(NB)
) (
  input  logic [LANES-1:0]    leader,
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES*BW-1:0] bank_flat,
  output logic [NB-1:0]       bank_en,
  output logic [NB*AW-1:0]    bank_addr
);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [BW-1:0] BID = BW'(b);

    // At most one leader per bank, so an AND-OR mux is exact
    always_comb begin
      bank_en[b]              = 1'b0;
      bank_addr[b*AW +: AW]   = '0;
      for (int i = 0; i < LANES; i++) begin
        if (leader[i] && (bank_flat[i*BW +: BW] == BID)) begin
          bank_en[b]            = 1'b1;
          bank_addr[b*AW +: AW] = bank_addr[b*AW +: AW] | addr_flat[i*AW +: AW];
        end
      end
    end
  end

endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
  import smem_arb_pkg::*;
#(
  parameter int unsigned LANES = ARB_LANES_DEF,
  parameter int unsigned AW    = ARB_AW_DEF,
  parameter int unsigned NB    = ARB_BANKS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_wide,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                pass_valid,
  output logic [LANES-1:0]    pass_grant,
  output logic [NB-1:0]       pass_bank_en,
  output logic [NB*AW-1:0]    pass_bank_addr,
  output logic                pass_last
);

  localparam int unsigned BW   = $clog2(NB);
  localparam int unsigned HALF = LANES / 2;
  localparam logic [LANES-1:0] LO_MASK = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};

  arb_state_e          state_q, state_d;
  logic [LANES-1:0]    pend_q, pend_d;
  logic                wide_q, wide_d;
  logic [LANES*AW-1:0] addr_q;

  logic                accept;
  logic                busy;
  logic [LANES-1:0]    scope_pend;
  logic [LANES-1:0]    leader;
  logic [LANES-1:0]    grant;
  logic [LANES*BW-1:0] bank_flat;
  logic [LANES*LANES-1:0] same_addr;
  logic                final_pass;

  assign busy   = (state_q == ARB_BUSY);
  assign accept = req_valid && !busy;

  // Group in service: whole set in wide mode, else lower half until empty
  always_comb begin
    if (!busy) begin
      scope_pend = '0;
    end else if (wide_q) begin
      scope_pend = pend_q;
    end else if (|(pend_q & LO_MASK)) begin
      scope_pend = pend_q & LO_MASK;
    end else begin
      scope_pend = pend_q & ~LO_MASK;
    end
  end

  smem_lane_cmp #(.LANES(LANES), .AW(AW), .NB(NB)) u_cmp (
    .wide      (wide_q),
    .addr_flat (addr_q),
    .bank_flat (bank_flat),
    .same_addr (same_addr)
  );

  smem_pass_pick #(.LANES(LANES), .BW(BW)) u_pick (
    .pend      (scope_pend),
    .bank_flat (bank_flat),
    .same_addr (same_addr),
    .leader    (leader),
    .grant     (grant)
  );

  smem_bank_route #(.LANES(LANES), .AW(AW), .NB(NB)) u_route (
    .leader    (leader),
    .addr_flat (addr_q),
    .bank_flat (bank_flat),
    .bank_en   (pass_bank_en),
    .bank_addr (pass_bank_addr)
  );

  assign final_pass = busy && ((pend_q & ~grant) == '0);

  // Next-state
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    wide_d  = wide_q;
    if (accept) begin
      state_d = ARB_BUSY;
      pend_d  = req_active;
      wide_d  = req_wide;
    end else if (busy) begin
      pend_d = pend_q & ~grant;
      if (final_pass) begin
        state_d = ARB_IDLE;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      pend_q  <= '0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      wide_q  <= wide_d;
    end
  end

  // Address holding register: data only, loaded on accept
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
    end
  end

  assign req_ready  = !busy;
  assign pass_valid = busy;
  assign pass_grant = grant;
  assign pass_last  = final_pass;

endmodule

// File: rtl/smem_bank_arbiter_chk.sv
module smem_bank_arbiter_chk #(
  parameter int unsigned LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_wide,
  input logic [LANES-1:0] req_active,
  input logic             pass_valid,
  input logic             pass_last,
  input logic [LANES-1:0] pass_grant
);

  localparam int unsigned HALF = LANES / 2;

  logic [LANES-1:0] owed_q;
  logic             wide_q;

  // Shadow of lanes still owed a grant, kept from the port view only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      wide_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      owed_q <= req_active;
      wide_q <= req_wide;
    end else if (pass_valid) begin
      owed_q <= owed_q & ~pass_grant;
    end
  end

  // R1
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !pass_valid);

  // R1
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> pass_valid);

  // R8
  grant_owed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> ((pass_grant & ~owed_q) == '0));

  // R9
  last_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && pass_last) |-> ((owed_q & ~pass_grant) == '0));

  // R9
  last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && pass_last) |=> req_ready);

  // R4
  pass_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && !pass_last) |-> (pass_grant != '0));

  // R6
  half_unmixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && !wide_q) |-> !((|pass_grant[HALF-1:0]) && (|pass_grant[LANES-1:HALF])));

  // R6
  low_half_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_valid && !wide_q && (|owed_q[HALF-1:0])) |-> (pass_grant[LANES-1:HALF] == '0));

endmodule

bind smem_bank_arbiter smem_bank_arbiter_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_wide   (req_wide),
  .req_active (req_active),
  .pass_valid (pass_valid),
  .pass_last  (pass_last),
  .pass_grant (pass_grant)
);

// File: tb/sim_smem_bank_arbiter.sv
module sim_smem_bank_arbiter;

  localparam int L  = 32;
  localparam int AW = 12;
  localparam int NB = 32;
  localparam int NV = 19;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic            req_wide;
  logic [L-1:0]    req_active;
  logic [L*AW-1:0] req_addr;
  logic            pass_valid;
  logic [L-1:0]    pass_grant;
  logic [NB-1:0]   pass_bank_en;
  logic [NB*AW-1:0] pass_bank_addr;
  logic            pass_last;

  always #5 clk = ~clk;

  smem_bank_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_active(req_active), .req_addr(req_addr),
    .pass_valid(pass_valid), .pass_grant(pass_grant), .pass_bank_en(pass_bank_en),
    .pass_bank_addr(pass_bank_addr), .pass_last(pass_last)
  );

  // {wide, active, kind, param, expected passes}
  // kind 0: lane*param, 1: param for all, 2: lane*32+param, 3: odd lanes param, even 0
  localparam logic [54:0] VECS [NV] = '{
    {1'b1, 32'hFFFFFFFF, 2'd0, 12'd1,  8'd1},
    {1'b0, 32'hFFFFFFFF, 2'd0, 12'd1,  8'd2},
    {1'b1, 32'hFFFFFFFF, 2'd0, 12'd2,  8'd2},
    {1'b0, 32'hFFFFFFFF, 2'd0, 12'd2,  8'd4},
    {1'b1, 32'hFFFFFFFF, 2'd1, 12'd7,  8'd1},
    {1'b0, 32'hFFFFFFFF, 2'd1, 12'd7,  8'd2},
    {1'b1, 32'hFFFFFFFF, 2'd2, 12'd3,  8'd32},
    {1'b0, 32'hFFFFFFFF, 2'd2, 12'd3,  8'd32},
    {1'b1, 32'h0000FFFF, 2'd2, 12'd3,  8'd16},
    {1'b0, 32'hFFFF0000, 2'd0, 12'd1,  8'd1},
    {1'b1, 32'h00000000, 2'd0, 12'd1,  8'd1},
    {1'b0, 32'h00000000, 2'd2, 12'd0,  8'd1},
    {1'b1, 32'h55555555, 2'd0, 12'd16, 8'd16},
    {1'b0, 32'hFFFFFFFF, 2'd0, 12'd16, 8'd32},
    {1'b1, 32'hFFFFFFFF, 2'd0, 12'd17, 8'd1},
    {1'b0, 32'hFFFFFFFF, 2'd0, 12'd17, 8'd2},
    {1'b1, 32'hFFFFFFFF, 2'd3, 12'd32, 8'd2},
    {1'b0, 32'hFFFFFFFF, 2'd3, 12'd32, 8'd4},
    {1'b1, 32'hFFFFFFFF, 2'd3, 12'd5,  8'd1}
  };

  int n_chk = 0;
  int n_bad = 0;

  logic [L-1:0]     g_rec  [64];
  logic [NB-1:0]    en_rec [64];
  logic [NB*AW-1:0] ba_rec [64];
  int   np;
  bit   no_pass;
  bit   ready_while_busy;
  bit   ready_after;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [AW-1:0] gen_addr(input logic [1:0] kind, input logic [11:0] p, input int lane);
    case (kind)
      2'd0:    return AW'(lane * int'(p));
      2'd1:    return p;
      2'd2:    return AW'(lane * 32 + int'(p));
      default: return (lane % 2 == 1) ? p : '0;
    endcase
  endfunction

  task automatic run_req(input logic w, input logic [L-1:0] act, input logic [L*AW-1:0] ad);
    @(negedge clk);
    req_valid  = 1'b1;
    req_wide   = w;
    req_active = act;
    req_addr   = ad;
    @(negedge clk);
    req_valid  = 1'b0;
    req_wide   = ~w;
    np = 0;
    no_pass = 1'b0;
    ready_while_busy = 1'b0;
    begin : walk
      while (np < 64) begin
        if (!pass_valid) begin
          no_pass = 1'b1;
          disable walk;
        end
        if (req_ready) ready_while_busy = 1'b1;
        g_rec[np]  = pass_grant;
        en_rec[np] = pass_bank_en;
        ba_rec[np] = pass_bank_addr;
        np++;
        if (pass_last) disable walk;
        @(negedge clk);
      end
    end
    @(negedge clk);
    ready_after = req_ready;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    logic [L*AW-1:0] ad;
    logic [L-1:0]    seen;
    bit              dup;
    req_valid  = 1'b0;
    req_wide   = 1'b0;
    req_active = '0;
    req_addr   = '0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(pass_valid == 1'b0, "R1 no pass in reset", 64'(pass_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && pass_valid == 1'b0, "R1 idle after reset", 64'({req_ready, pass_valid}), 64'd2);

    // Table walk: pass count (R9, R4, R5, R6, R7, R8) and lane coverage
    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [31:0] a;
      logic [1:0]  k;
      logic [11:0] p;
      logic [7:0]  e;
      {w, a, k, p, e} = VECS[v];
      for (int i = 0; i < L; i++) ad[i*AW +: AW] = gen_addr(k, p, i);
      run_req(w, a, ad);
      chk(!no_pass && np == int'(e), $sformatf("R9 pass count vec %0d", v), 64'(np), 64'(e));
      seen = '0;
      dup  = 1'b0;
      for (int n = 0; n < np; n++) begin
        if ((seen & g_rec[n]) != '0) dup = 1'b1;
        seen |= g_rec[n];
      end
      chk(!dup && seen == a, $sformatf("R8 lanes granted once vec %0d", v), 64'(seen), 64'(a));
      chk(!ready_while_busy && ready_after, $sformatf("R1 ready handshake vec %0d", v),
          64'({ready_while_busy, ready_after}), 64'd1);
    end

    // R4 R5 R3: lanes 3,9 @0x40 and 5 @0x20 share bank 0; lane 12 @0x07 in bank 7
    ad = '0;
    ad[3*AW +: AW]  = 12'h040;
    ad[5*AW +: AW]  = 12'h020;
    ad[9*AW +: AW]  = 12'h040;
    ad[12*AW +: AW] = 12'h007;
    run_req(1'b1, 32'h0000_1228, ad);
    chk(np == 2, "R4 conflict needs two passes", 64'(np), 64'd2);
    chk(g_rec[0] == 32'h0000_1208, "R5 same word merged with lowest lane", 64'(g_rec[0]), 64'h1208);
    chk(g_rec[1] == 32'h0000_0020, "R4 waiting lane served later", 64'(g_rec[1]), 64'h20);
    chk(en_rec[0] == 32'h0000_0081, "R3 bank enables pass 1", 64'(en_rec[0]), 64'h81);
    chk(ba_rec[0][0 +: AW] == 12'h040 && ba_rec[0][7*AW +: AW] == 12'h007,
        "R3 bank addresses pass 1", 64'({ba_rec[0][0 +: AW], ba_rec[0][7*AW +: AW]}), 64'h040007);
    chk(en_rec[1] == 32'h1 && ba_rec[1][0 +: AW] == 12'h020, "R3 bank address pass 2",
        64'({en_rec[1], ba_rec[1][0 +: AW]}), 64'h1020);

    // R6: lanes 0 and 16 in different banks still split in narrow mode
    ad = '0;
    ad[0*AW +: AW]  = 12'h001;
    ad[16*AW +: AW] = 12'h002;
    run_req(1'b0, 32'h0001_0001, ad);
    chk(np == 2 && g_rec[0] == 32'h1 && g_rec[1] == 32'h0001_0000, "R6 lower half first",
        64'({g_rec[0], g_rec[1]}), {32'h1, 32'h0001_0000});
    // R7: same lanes share one pass in wide mode
    run_req(1'b1, 32'h0001_0001, ad);
    chk(np == 1 && g_rec[0] == 32'h0001_0001, "R7 no split in wide mode", 64'(np), 64'd1);

    // R7: addresses 0 and 32 collide across halves in wide mode
    ad = '0;
    ad[16*AW +: AW] = 12'h020;
    run_req(1'b1, 32'h0001_0001, ad);
    chk(np == 2 && g_rec[0] == 32'h1, "R7 cross-half conflict", 64'({np[7:0], g_rec[0]}), {8'd2, 32'h1});

    // R2: addresses 0 and 16 are banks 0/16 in wide mode, both bank 0 in narrow mode
    ad = '0;
    ad[1*AW +: AW] = 12'h010;
    run_req(1'b1, 32'h3, ad);
    chk(np == 1 && en_rec[0] == 32'h0001_0001, "R2 wide bank index", 64'(en_rec[0]), 64'h0001_0001);
    run_req(1'b0, 32'h3, ad);
    chk(np == 2 && en_rec[0] == 32'h1 && en_rec[1] == 32'h1, "R2 narrow bank index",
        64'({en_rec[0], en_rec[1]}), {32'h1, 32'h1});

    // R2: upper bank outputs unused in narrow mode
    for (int i = 0; i < L; i++) ad[i*AW +: AW] = AW'(i);
    run_req(1'b0, 32'hFFFF_FFFF, ad);
    chk(en_rec[0][31:16] == 16'h0 && en_rec[1][31:16] == 16'h0, "R2 upper banks idle",
        64'({en_rec[0][31:16], en_rec[1][31:16]}), 64'd0);

    // R8: empty access gives one pass with zero grant
    run_req(1'b1, 32'h0, ad);
    chk(np == 1 && g_rec[0] == '0 && en_rec[0] == '0, "R8 empty access", 64'(g_rec[0]), 64'd0);

    report();
  end

endmodule